// File: doc/BRIEF.md
# E1 Frame Alignment Synchronizer

This block is the receive-side frame aligner of an E1 line interface. It takes the recovered serial bit stream, one bit per cycle in which `bit_en` is high, and searches for the frame alignment word. The alignment word is the bit pattern 0011011 in bits 2 to 8 of time slot 0 of every second frame. Once alignment is confirmed, the block tracks the frame and time-slot position. It checks every alignment word, and it can also check the service bit (bit 2 of time slot 0 in the frames without an alignment word). It falls back to the asynchronous state when either kind of word is wrong a set number of times in a row.

While asynchronous, the block raises a loss-of-alignment flag and requests all-ones (AIS) substitution toward the system side. It also freezes the capture of received service bits and stops the framing error counter. The search for a new alignment begins at once. A force command drops the block out of alignment on request. A read-clear strobe empties the error counter.

Top module: `e1fa_sync`

## Requirements
- R1: After reset `loa` is 1, `loa_irq` is 0, `fec_cnt` is 0, and `svc_hold` is 1. `ais_en` is 1 while `ais_auto_dis` is 0.
- R2: Alignment is gained only after three checks in a row: the word 0011011 in bits 2 to 8 of time slot 0 of frame n (bit 1 of a slot is sent first), bit 2 equal to 1 in frame n+1, and 0011011 again in frame n+2. If a verification step fails, the search resumes with the next received bit.
- R3: While aligned, `slot_idx`/`bit_idx` give the time slot (0 to 31) and bit (0 to 7) of the last accepted bit. `frm_is_fas` is 1 during frames that carry the alignment word.
- R4: With `thr4_sel`=0, three consecutive wrong alignment words cause loss of alignment on the third one.
- R5: With `thr4_sel`=1, three consecutive wrong alignment words keep alignment and the fourth causes loss.
- R6: A service word is wrong when bit 2 of time slot 0 of a frame without the alignment word is 0. The same number of consecutive wrong service words causes loss, counted apart from alignment-word errors.
- R7: A correct word resets the consecutive-error run of its own kind, so errors that are not consecutive do not cause loss.
- R8: With `svc_chk_dis`=1, wrong service words have no effect on alignment.
- R9: `fec_cnt` rises by one for each wrong alignment word while aligned and does not change while asynchronous. A `fec_rd_clr` strobe clears it. If a strobe coincides with an increment, the result is 1. The counter saturates at its maximum value.
- R10: Each loss of alignment gives exactly one `loa_irq` pulse, one cycle wide, in the cycle `loa` rises.
- R11: `ais_en` equals `loa` while `ais_auto_dis` is 0 and is 0 while it is 1. `svc_hold` equals `loa`.
- R12: A `force_resync` pulse while aligned sets `loa` in the next cycle and gives an interrupt pulse. During verification it returns the search to the hunting state.
- R13: After a loss, a new alignment is acquired by R2 without any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | A received bit is present this cycle |
| rx_bit | input | 1 | Received serial bit |
| thr4_sel | input | 1 | 1: four consecutive errors for loss; 0: three |
| svc_chk_dis | input | 1 | Ignore service-word errors |
| force_resync | input | 1 | Drop out of alignment and search again |
| ais_auto_dis | input | 1 | Suppress the automatic AIS request |
| fec_rd_clr | input | 1 | Clear the framing error counter |
| loa | output | 1 | Loss of alignment (asynchronous state) |
| loa_irq | output | 1 | One-cycle pulse on entry to the asynchronous state |
| fec_cnt | output | FEC_W | Framing error count |
| slot_idx | output | log2(FRAME_BITS)-3 | Time slot of the last bit |
| bit_idx | output | 3 | Bit within the slot of the last bit |
| frm_is_fas | output | 1 | Current frame carries the alignment word |
| ais_en | output | 1 | Request all-ones substitution downstream |
| svc_hold | output | 1 | Freeze received service-bit capture |

## Verification
Two functions can land in the same cycle: the error counter's read-clear strobe and the counter's increment on a wrong alignment word. The bench provokes this by raising `fec_rd_clr` together with the eighth time-slot-0 bit of a corrupted alignment frame, and it expects the counter to read 1 afterwards. A second overlap is the third (or fourth) wrong word: in that one cycle the counter counts the error and the block loses alignment. The bench judges this by requiring both the new count and `loa`=1 after that frame.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
   typedef enum logic [1:0] {
      AL_HUNT     = 2'd0,
      AL_VER_NFAS = 2'd1,
      AL_VER_FAS  = 2'd2,
      AL_LOCK     = 2'd3
   } al_state_t;

   localparam int FAS_LEN = 7;
   localparam logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011;
   localparam int TS0_END_POS = 7;
endpackage

// File: rtl/e1fa_ts0_track.sv
module e1fa_ts0_track
   import e1fa_pkg::*;
#(
   parameter int FRAME_BITS = 256,
   parameter int POS_W      = $clog2(FRAME_BITS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic               rx_bit,
   input  logic               realign,
   output logic [FAS_LEN-1:0] fas_win,
   output logic               byte_done,
   output logic [POS_W-1:0]   pos,
   output logic               fas_frm
);
   localparam logic [POS_W-1:0] POS_LOAD = POS_W'(TS0_END_POS);
   localparam logic [POS_W-1:0] POS_PRE  = POS_W'(TS0_END_POS - 1);

   if (FRAME_BITS < 16 || (1 << POS_W) != FRAME_BITS) begin : g_bad_frame
      $error("FRAME_BITS must be a power of two of at least 16");
   end

   logic [FAS_LEN-2:0] hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '1;
      end else if (bit_en) begin
         hist_q <= {hist_q[FAS_LEN-3:0], rx_bit};
      end
   end

   assign fas_win   = {hist_q, rx_bit};
   assign byte_done = bit_en && (pos == POS_PRE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos     <= '1;
         fas_frm <= 1'b0;
      end else if (bit_en) begin
         if (realign) begin
            pos     <= POS_LOAD;
            fas_frm <= 1'b1;
         end else begin
            pos <= pos + 1'b1;
            if (pos == '1) fas_frm <= ~fas_frm;
         end
      end
   end

   // R3: the frame type flag only changes on a frame wrap or a realignment
   a_r3_type_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!realign && (pos != '1)) |=> $stable(fas_frm));
endmodule

// File: rtl/e1fa_err_mon.sv
module e1fa_err_mon #(
   parameter int CNT_W  = 3,
   parameter int N_KIND = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              thr4,
   input  logic [N_KIND-1:0] chk,
   input  logic [N_KIND-1:0] bad,
   output logic              trip
);
   localparam logic [CNT_W-1:0] THR_LO = CNT_W'(3);
   localparam logic [CNT_W-1:0] THR_HI = CNT_W'(4);

   if (CNT_W < 3) begin : g_bad_cnt
      $error("CNT_W must hold the value 4");
   end

   logic [CNT_W-1:0]  thr;
   logic [N_KIND-1:0] hit_v;

   assign thr = thr4 ? THR_HI : THR_LO;

   for (genvar k = 0; k < N_KIND; k++) begin : g_kind
      logic [CNT_W-1:0] run_q;

      assign hit_v[k] = chk[k] && bad[k] && (run_q == thr - CNT_W'(1));

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            run_q <= '0;
         end else if (chk[k]) begin
            run_q <= bad[k] ? run_q + 1'b1 : '0;
         end
      end

      // R5: a run never passes the larger threshold
      a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
         run_q <= THR_HI);
   end

   assign trip = |hit_v;
endmodule

// File: rtl/e1fa_fec.sv
module e1fa_fec #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   if (W < 4) begin : g_bad_w
      $error("error counter width must be at least 4");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= inc ? W'(1) : '0;
      end else if (inc && (cnt != '1)) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9: a full counter stays full until cleared
   a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == '1) && !clr) |=> (cnt == '1));
endmodule

// File: rtl/e1fa_sync.sv
module e1fa_sync
   import e1fa_pkg::*;
#(
   parameter int FRAME_BITS  = 256,
   parameter int FEC_W       = 16,
   parameter int RUN_W       = 3,
   parameter bit HAS_SVC_CHK = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bit_en,
   input  logic                          rx_bit,
   input  logic                          thr4_sel,
   input  logic                          svc_chk_dis,
   input  logic                          force_resync,
   input  logic                          ais_auto_dis,
   input  logic                          fec_rd_clr,
   output logic                          loa,
   output logic                          loa_irq,
   output logic [FEC_W-1:0]              fec_cnt,
   output logic [$clog2(FRAME_BITS)-4:0] slot_idx,
   output logic [2:0]                    bit_idx,
   output logic                          frm_is_fas,
   output logic                          ais_en,
   output logic                          svc_hold
);
   localparam int POS_W  = $clog2(FRAME_BITS);
   localparam int N_KIND = 2;

   al_state_t          st_q, st_d;
   logic [FAS_LEN-1:0] fas_win;
   logic               byte_done, fas_frm, realign;
   logic [POS_W-1:0]   pos;
   logic               fas_hit, nfas_hit, locked;
   logic [N_KIND-1:0]  chk, bad;
   logic               trip, loss, fec_inc, irq_q;

   e1fa_ts0_track #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_track (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .realign(realign), .fas_win(fas_win), .byte_done(byte_done),
      .pos(pos), .fas_frm(fas_frm));

   assign fas_hit  = (fas_win == FAS_WORD);
   assign nfas_hit = fas_win[FAS_LEN-1];
   assign locked   = (st_q == AL_LOCK);

   assign chk[0] = locked && byte_done && fas_frm;
   assign bad[0] = !fas_hit;
   assign bad[1] = !nfas_hit;

   if (HAS_SVC_CHK) begin : g_svc
      assign chk[1] = locked && byte_done && !fas_frm && !svc_chk_dis;
   end else begin : g_no_svc
      assign chk[1] = 1'b0;
   end

   e1fa_err_mon #(.CNT_W(RUN_W), .N_KIND(N_KIND)) u_err (
      .clk(clk), .rst_n(rst_n), .clr(!locked), .thr4(thr4_sel),
      .chk(chk), .bad(bad), .trip(trip));

   assign loss    = locked && (trip || force_resync);
   assign fec_inc = chk[0] && bad[0];

   e1fa_fec #(.W(FEC_W)) u_fec (
      .clk(clk), .rst_n(rst_n), .inc(fec_inc), .clr(fec_rd_clr),
      .cnt(fec_cnt));

   always_comb begin
      st_d    = st_q;
      realign = 1'b0;
      unique case (st_q)
         AL_HUNT: begin
            if (bit_en && fas_hit) begin
               st_d    = AL_VER_NFAS;
               realign = 1'b1;
            end
         end
         AL_VER_NFAS: begin
            if (force_resync)   st_d = AL_HUNT;
            else if (byte_done) st_d = nfas_hit ? AL_VER_FAS : AL_HUNT;
         end
         AL_VER_FAS: begin
            if (force_resync)   st_d = AL_HUNT;
            else if (byte_done) st_d = fas_hit ? AL_LOCK : AL_HUNT;
         end
         AL_LOCK: begin
            if (loss) st_d = AL_HUNT;
         end
         default: st_d = AL_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= AL_HUNT;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         irq_q <= loss;
      end
   end

   assign loa        = !locked;
   assign loa_irq    = irq_q;
   assign ais_en     = loa && !ais_auto_dis;
   assign svc_hold   = loa;
   assign slot_idx   = pos[POS_W-1:3];
   assign bit_idx    = pos[2:0];
   assign frm_is_fas = fas_frm;

   // R10: the interrupt accompanies every entry into the asynchronous state
   a_r10_irq_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loa) |-> loa_irq);

   // R10: the interrupt is a single-cycle pulse
   a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      loa_irq |=> !loa_irq);

   // R9: no counting while asynchronous
   a_r9_fec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (loa && !fec_rd_clr) |=> $stable(fec_cnt));

   // R12: a force command always leaves the block out of alignment
   a_r12_force: assert property (@(posedge clk) disable iff (!rst_n)
      force_resync |=> loa);

   // R2: alignment is only gained on a received bit
   a_r2_lock_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loa) |-> $past(bit_en));
endmodule

// File: tb/tb_e1fa_sync.sv
`timescale 1ns/1ps
module tb_e1fa_sync;
   localparam int FB = 256;
   localparam logic [7:0] FAS_BYTE = 8'b1001_1011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, rx_bit = 1'b1, thr4_sel = 1'b0, svc_chk_dis = 1'b0;
   logic force_resync = 1'b0, ais_auto_dis = 1'b0, fec_rd_clr = 1'b0;
   logic loa, loa_irq, frm_is_fas, ais_en, svc_hold;
   logic [15:0] fec_cnt;
   logic [4:0]  slot_idx;
   logic [2:0]  bit_idx;

   int  n_chk = 0, n_fail = 0, irq_cnt = 0, exp_irq = 0, exp_fec = 0, fidx = 0;
   bit  prev_bit = 1'b1, done = 1'b0;

   always #4 clk = ~clk;

   e1fa_sync dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .thr4_sel(thr4_sel), .svc_chk_dis(svc_chk_dis),
      .force_resync(force_resync), .ais_auto_dis(ais_auto_dis),
      .fec_rd_clr(fec_rd_clr), .loa(loa), .loa_irq(loa_irq),
      .fec_cnt(fec_cnt), .slot_idx(slot_idx), .bit_idx(bit_idx),
      .frm_is_fas(frm_is_fas), .ais_en(ais_en), .svc_hold(svc_hold));

   always @(negedge clk) if (rst_n && loa_irq) irq_cnt++;

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int fec_step(int cur, bit inc, bit clr);
      if (clr) return inc ? 1 : 0;
      if (inc && cur < 65535) return cur + 1;
      return cur;
   endfunction

   // payload bits never hold two zeros in a row, so only true words match
   function automatic bit rnd_bit();
      if (!prev_bit) return 1'b1;
      return 1'($urandom_range(0, 1));
   endfunction

   task automatic send_bit(input bit v, input bit clr);
      if ($urandom_range(0, 3) == 0) repeat (1 + $urandom_range(0, 1)) @(negedge clk);
      bit_en = 1'b1; rx_bit = v; fec_rd_clr = clr;
      prev_bit = v;
      @(negedge clk);
      bit_en = 1'b0; fec_rd_clr = 1'b0;
   endtask

   task automatic send_frame(input bit good, input bit clr_end);
      bit is_fas = (fidx % 2 == 0);
      for (int i = 0; i < FB; i++) begin
         bit v;
         if (i < 8) begin
            if (is_fas)      v = good ? FAS_BYTE[7-i] : 1'b1;
            else if (i == 0) v = 1'b1;
            else if (i == 1) v = good;
            else             v = rnd_bit();
         end else begin
            v = rnd_bit();
         end
         send_bit(v, clr_end && (i == 7));
      end
      if (is_fas) exp_fec = fec_step(exp_fec, !good && !loa_pre, clr_end);
      else if (clr_end) exp_fec = fec_step(exp_fec, 1'b0, 1'b1);
      fidx++;
   endtask

   bit loa_pre;  // alignment state as seen by the bench model at frame start

   task automatic frame(input bit good, input bit clr_end = 1'b0);
      loa_pre = loa;
      send_frame(good, clr_end);
   endtask

   initial begin
      void'($urandom(32'd5581));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 loa", loa, 1); check("R1 irq", loa_irq, 0);
      check("R1 fec", fec_cnt, 0); check("R1 hold", svc_hold, 1);
      check("R1 ais", ais_en, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 acquisition
      frame(1); frame(1);
      check("R2 not yet aligned", loa, 1);
      frame(1);
      check("R2 aligned", loa, 0);
      check("R3 slot", slot_idx, 31); check("R3 bit", bit_idx, 7);
      check("R3 fas frame", frm_is_fas, 1);
      check("R11 hold off", svc_hold, 0);
      frame(1);
      check("R3 nfas frame", frm_is_fas, 0);

      // R7 and R4
      frame(0); frame(1); frame(0); frame(1); frame(1); frame(1);
      frame(0); frame(1); frame(0);
      check("R7 non-consecutive", loa, 0);
      check("R9 count", fec_cnt, exp_fec);
      frame(1); frame(0);
      exp_irq++;
      check("R4 loss at three", loa, 1);
      check("R9 count at loss", fec_cnt, exp_fec);
      check("R10 irq", irq_cnt, exp_irq);
      check("R11 ais", ais_en, 1); check("R11 hold", svc_hold, 1);

      // R9 frozen while async, R13 automatic reacquisition
      frame(1); frame(0);
      check("R9 frozen", fec_cnt, exp_fec);
      frame(1); frame(1); frame(1); frame(1);
      check("R13 reacquired", loa, 0);

      // R5 four-error threshold
      thr4_sel = 1'b1;
      frame(1); frame(0); frame(1); frame(0); frame(1); frame(0); frame(1);
      check("R5 three not enough", loa, 0);
      frame(0);
      exp_irq++;
      check("R5 loss at four", loa, 1);
      check("R5 count", fec_cnt, exp_fec);
      thr4_sel = 1'b0;
      frame(1); frame(1); frame(1); frame(1);
      check("R13 reacquired again", loa, 0);

      // R6 service-word errors
      frame(0); frame(1); frame(0); frame(1);
      check("R6 two service errors", loa, 0);
      frame(0);
      exp_irq++;
      check("R6 loss", loa, 1);
      check("R6 no fec change", fec_cnt, exp_fec);
      frame(1); frame(1); frame(1);
      check("R13 after service loss", loa, 0);

      // R8 service check disabled
      svc_chk_dis = 1'b1;
      frame(0); frame(1); frame(0); frame(1); frame(0); frame(1); frame(0);
      check("R8 ignored", loa, 0);
      svc_chk_dis = 1'b0;
      frame(1);

      // R9 clear alone, then clear together with an increment
      fec_rd_clr = 1'b1; @(negedge clk); fec_rd_clr = 1'b0;
      exp_fec = 0;
      check("R9 clear", fec_cnt, 0);
      frame(1); frame(0, 1'b1);
      check("R9 clear with increment", fec_cnt, 1);
      check("R9 model", exp_fec, 1);

      // R12 forced resync
      force_resync = 1'b1; @(negedge clk); force_resync = 1'b0;
      exp_irq++;
      check("R12 loa", loa, 1);
      ais_auto_dis = 1'b1;
      @(negedge clk);
      check("R12 irq", irq_cnt, exp_irq);
      check("R11 ais disabled", ais_en, 0);
      check("R11 hold kept", svc_hold, 1);
      // R2 failed verification restarts search
      frame(1); frame(1); frame(0); frame(1);
      check("R2 restarted", loa, 1);
      frame(1); frame(1);
      check("R2 aligned after restart", loa, 0);
      ais_auto_dis = 1'b0;

      // constrained random frames while aligned
      begin
         int thr, fa = 0, sv = 0;
         bit lost = 1'b0;
         thr4_sel = 1'($urandom_range(0, 1));
         thr = thr4_sel ? 4 : 3;
         for (int k = 0; k < 40 && !lost; k++) begin
            bit good = ($urandom_range(0, 2) != 0);
            bit is_fas = (fidx % 2 == 0);
            frame(good);
            if (is_fas) fa = good ? 0 : fa + 1;
            else        sv = good ? 0 : sv + 1;
            if (fa == thr || sv == thr) lost = 1'b1;
            check(is_fas ? "R4 random loa" : "R6 random loa", loa, lost);
            check("R9 random fec", fec_cnt, exp_fec);
         end
         if (lost) exp_irq++;
         @(negedge clk);
         check("R10 random irq", irq_cnt, exp_irq);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule